// File: doc/BRIEF.md
# Adaptive Voltage Serial Command Master

This block is the serial master for a voltage-regulator command link. It takes command fields on a valid/ready interface and composes a 32-bit frame from them: a fixed start code, command type, command group, data type, rail select, a 16-bit payload and a 3-bit CRC that it computes itself. It then shifts the frame out most significant bit first on a clock that idles low. After an optional gap it clocks a second 32-bit frame, during which it samples the regulator's reply on the data-in pin. The reply is held in a response register. A sticky done flag records that the exchange has finished.

A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and the fields are sampled on that edge. `cmd_ready` is low from the cycle after acceptance until the reply frame ends. A source may hold `cmd_valid` high for any length of time and the command waits. A request presented while the block is busy is not taken. A mode input replaces the composed frame with an idle frame of all ones. The serial bit rate comes from a runtime divider and the gap between the frames is a runtime count of system clocks.

Top module: `avs_frame_master`

## Requirements
- R1: The outgoing frame, from bit 31 (first sent) down to bit 0, is: [31:30] start code 01, [29:28] command type, [27] command group, [26:23] data type, [22:19] rail select, [18:3] payload, [2:0] CRC.
- R2: The CRC in bits [2:0] is the remainder after dividing bits [31:3], followed by three zero bits, by the polynomial x^3+x+1 (binary 1011).
- R3: When `cmd_idle` is high at acceptance, the outgoing frame is 32 ones and the command fields have no effect.
- R4: Bits leave MSB first. `mosi` changes only while `sclk` is low and holds steady for the whole time `sclk` is high.
- R5: `sclk` is low whenever the block is not busy. `mosi` rests at 1 when no frame is being sent.
- R6: `cmd_ready` equals the inverse of `busy`. `busy` rises on the cycle after acceptance. A `cmd_valid` held while busy changes neither the frame nor the timing of the exchange in progress.
- R7: One exchange gives exactly 64 rising edges of `sclk`: 32 for the outgoing frame and 32 for the reply.
- R8: `miso` is sampled on the rising `sclk` edges of the second frame, MSB first. `rsp_data` changes only on the cycle the exchange ends.
- R9: `done` is set when an exchange ends and stays set until `done_clr` is high. If both happen on the same edge, the set wins.
- R10: Between the two frames, `sclk` stays low and `mosi` stays high for `frame_gap` system clock cycles. A value of 0 means no gap.
- R11: Each bit lasts 8*(`clk_div`+1) system clock cycles, so `busy` stays high for 512*(`clk_div`+1)+`frame_gap` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted (not busy) |
| cmd_idle | input | 1 | Send an all-ones idle frame instead of a command |
| cmd_type | input | 2 | Command type (00 write-and-commit, 11 read) |
| cmd_group | input | 1 | Command group |
| cmd_dtype | input | 4 | Command data type |
| cmd_rail | input | 4 | Rail select |
| cmd_data | input | 16 | Command payload (0xFFFF for reads) |
| clk_div | input | 10 | Bit clock divider: one phase tick every clk_div+1 cycles |
| frame_gap | input | 17 | Cycles of gap between the two frames |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Exchange in progress |
| rsp_data | output | 32 | Last captured reply frame |
| done | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Clears `done` |

## Verification
The embedded properties watch, on every cycle, the link-level rules: a low resting clock, data held while the clock is high, no acceptance while busy, busy following an acceptance, the gap shape, the reply register changing only as busy falls, and the set/clear behaviour of the done flag. The frame contents, the CRC value, the exact count of clock edges, the reply bit order and the total exchange length in cycles for a given divider and gap can only be shown by the bench's scenarios. In those scenarios a modelled regulator captures each frame and feeds back a known reply, and the bench compares the results against layouts and CRCs it computes itself.

// File: rtl/avs_pkg.sv
package avs_pkg;
  localparam int FRAME_W = 32;
  localparam int CRC_W   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_GAP, ST_RX} avs_state_e;

  // Remainder of msg*x^3 divided by x^3+x+1, by long division
  function automatic logic [CRC_W-1:0] crc3(input logic [FRAME_W-CRC_W-1:0] msg);
    logic [FRAME_W-1:0] rem;
    rem = {msg, {CRC_W{1'b0}}};
    for (int i = FRAME_W - 1; i >= CRC_W; i--) begin
      if (rem[i]) rem[i-:4] = rem[i-:4] ^ 4'b1011;
    end
    return rem[CRC_W-1:0];
  endfunction
endpackage

// File: rtl/avs_tick_gen.sv
module avs_tick_gen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  // R11: tick spacing never exceeds the divider
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(div)) |-> (cnt <= div));
endmodule

// File: rtl/avs_frame_build.sv
module avs_frame_build
  import avs_pkg::*;
(
  input  logic               idle,
  input  logic [1:0]         ctype,
  input  logic               cgroup,
  input  logic [3:0]         dtype,
  input  logic [3:0]         rail,
  input  logic [15:0]        data,
  output logic [FRAME_W-1:0] frame
);
  logic [FRAME_W-CRC_W-1:0] body;

  always_comb begin
    body = {2'b01, ctype, cgroup, dtype, rail, data};
    if (idle) frame = '1;
    else      frame = {body, crc3(body)};
  end
endmodule

// File: rtl/avs_shifter.sv
module avs_shifter
  import avs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               tx_shift,
  input  logic               rx_sample,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx_word
);
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1;
      rx_sh <= '0;
    end else begin
      if (load)          tx_sh <= load_val;
      else if (tx_shift) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b1};
      if (load)           rx_sh <= '0;
      else if (rx_sample) rx_sh <= {rx_sh[FRAME_W-2:0], miso};
    end
  end

  assign mosi    = tx_sh[FRAME_W-1];
  assign rx_word = rx_sh;

  // R6: never load and shift in the same cycle
  p_load_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(tx_shift || rx_sample));
endmodule

// File: rtl/avs_frame_master.sv
module avs_frame_master
  import avs_pkg::*;
#(
  parameter int DIV_W   = 10,
  parameter int GAP_W   = 17,
  parameter int PHASES  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_idle,
  input  logic [1:0]         cmd_type,
  input  logic               cmd_group,
  input  logic [3:0]         cmd_dtype,
  input  logic [3:0]         cmd_rail,
  input  logic [15:0]        cmd_data,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [GAP_W-1:0]   frame_gap,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               busy,
  output logic [FRAME_W-1:0] rsp_data,
  output logic               done,
  input  logic               done_clr
);
  localparam int PH_W  = $clog2(PHASES);
  localparam int HALF  = PHASES / 2;
  localparam int BIT_W = $clog2(FRAME_W);

  avs_state_e         state;
  logic [PH_W-1:0]    ph;
  logic [BIT_W-1:0]   bcnt;
  logic [GAP_W-1:0]   gap_cnt;
  logic               tick, accept, bit_end, frame_end, sample;
  logic [FRAME_W-1:0] frame, rx_word;

  assign accept    = cmd_valid && cmd_ready;
  assign bit_end   = tick && (ph == PH_W'(PHASES - 1));
  assign frame_end = bit_end && (bcnt == BIT_W'(FRAME_W - 1));
  assign sample    = tick && (state == ST_RX) && (ph == PH_W'(HALF - 1));

  avs_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  ((state == ST_TX) || (state == ST_RX)),
    .div  (clk_div),
    .tick (tick)
  );

  avs_frame_build u_build (
    .idle  (cmd_idle),
    .ctype (cmd_type),
    .cgroup(cmd_group),
    .dtype (cmd_dtype),
    .rail  (cmd_rail),
    .data  (cmd_data),
    .frame (frame)
  );

  avs_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (frame),
    .tx_shift (bit_end && (state == ST_TX)),
    .rx_sample(sample),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ph       <= '0;
      bcnt     <= '0;
      gap_cnt  <= '0;
      rsp_data <= '0;
      done     <= 1'b0;
    end else begin
      if (accept || state == ST_GAP) begin
        ph   <= '0;
        bcnt <= '0;
      end else if (tick) begin
        ph <= (ph == PH_W'(PHASES - 1)) ? '0 : ph + 1'b1;
        if (bit_end) bcnt <= (frame_end) ? '0 : bcnt + 1'b1;
      end

      unique case (state)
        ST_IDLE: if (accept) state <= ST_TX;
        ST_TX: if (frame_end) begin
          gap_cnt <= frame_gap;
          state   <= (frame_gap == '0) ? ST_RX : ST_GAP;
        end
        ST_GAP: begin
          if (gap_cnt <= GAP_W'(1)) state <= ST_RX;
          else                      gap_cnt <= gap_cnt - 1'b1;
        end
        ST_RX: if (frame_end) begin
          state    <= ST_IDLE;
          rsp_data <= rx_word;
        end
        default: state <= ST_IDLE;
      endcase

      if (state == ST_RX && frame_end) done <= 1'b1;
      else if (done_clr)               done <= 1'b0;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = !busy;
  assign sclk      = ((state == ST_TX) || (state == ST_RX)) && (ph >= PH_W'(HALF));

  // R5: clock rests low outside an exchange
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && mosi));
  // R4: data held while clock is high
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R6: busy follows an accepted command
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R6: no acceptance while busy
  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  // R8: reply register only moves as the exchange ends
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_data) |-> $fell(busy));
  // R9: done set at the end of every exchange
  p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9: clear wins when no exchange ends on that edge
  p_done_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_clr) && !$fell(busy)) |-> !done);
  // R10: gap keeps clock low and data high
  p_gap_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (!sclk && mosi));
endmodule

// File: tb/sim_avs_frame_master.sv
module sim_avs_frame_master;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_idle = 0, cmd_group = 0, miso = 0, done_clr = 0;
  logic [1:0]  cmd_type = 0;
  logic [3:0]  cmd_dtype = 0, cmd_rail = 0;
  logic [15:0] cmd_data = 0;
  logic [9:0]  clk_div = 0;
  logic [16:0] frame_gap = 0;
  logic        cmd_ready, sclk, mosi, busy, done;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;
  int rises = 0;
  logic [31:0] cap = 0, rsp_word = 0;

  always #4 clk = ~clk;

  avs_frame_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idle(cmd_idle), .cmd_type(cmd_type), .cmd_group(cmd_group),
    .cmd_dtype(cmd_dtype), .cmd_rail(cmd_rail), .cmd_data(cmd_data),
    .clk_div(clk_div), .frame_gap(frame_gap), .sclk(sclk), .mosi(mosi),
    .miso(miso), .busy(busy), .rsp_data(rsp_data), .done(done), .done_clr(done_clr)
  );

  // Regulator model: capture outgoing bits, feed back reply bits
  always @(posedge sclk) begin
    if (rises < 32) cap = {cap[30:0], mosi};
    rises = rises + 1;
  end
  always @(negedge sclk) begin
    if (rises >= 32 && rises < 64) miso = rsp_word[31 - (rises - 32)];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serial CRC, shift-register form
  function automatic logic [2:0] ref_crc(input logic [28:0] m);
    logic [2:0] r = 3'b000;
    logic fb;
    for (int i = 28; i >= 0; i--) begin
      fb = m[i] ^ r[2];
      r  = {r[1], r[0] ^ fb, fb};
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_frame(input logic idl, input logic [1:0] t,
      input logic g, input logic [3:0] dt, input logic [3:0] rl, input logic [15:0] d);
    logic [28:0] b;
    b = {2'b01, t, g, dt, rl, d};
    return idl ? 32'hFFFF_FFFF : {b, ref_crc(b)};
  endfunction

  task automatic txn(input logic idl, input logic [1:0] t, input logic g,
      input logic [3:0] dt, input logic [3:0] rl, input logic [15:0] d,
      input logic [31:0] w, input logic [9:0] dv, input logic [16:0] gp, input bit poke);
    int len = 0;
    logic [31:0] exp_f;
    exp_f = ref_frame(idl, t, g, dt, rl, d);
    @(negedge clk);
    rises = 0; rsp_word = w; clk_div = dv; frame_gap = gp;
    cmd_idle = idl; cmd_type = t; cmd_group = g; cmd_dtype = dt; cmd_rail = rl; cmd_data = d;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk("R6 busy after accept", {31'd0, busy}, 32'd1);
    chk("R6 ready low while busy", {31'd0, cmd_ready}, 32'd0);
    while (busy) begin
      len++;
      if (poke && len == 5) begin
        cmd_valid = 1; cmd_rail = ~rl; cmd_data = ~d; cmd_idle = ~idl;
      end
      if (poke && len == 40) cmd_valid = 0;
      @(negedge clk);
    end
    cmd_valid = 0;
    chk(idl ? "R3 idle frame" : "R1 R2 frame and CRC", cap, exp_f);
    chk("R7 rising edges", rises, 64);
    chk("R8 reply capture", rsp_data, w);
    chk("R11 R10 exchange length", len, 512 * (dv + 1) + gp);
    chk("R9 done set", {31'd0, done}, 32'd1);
    chk("R5 idle levels", {30'd0, sclk, mosi}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset idle levels", {29'd0, busy, sclk, mosi}, 32'd1);
    chk("R8 reset reply", rsp_data, 32'd0);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R6 ready at rest", {31'd0, cmd_ready}, 32'd1);

    // Sweep over every rail and command type with varied fields
    for (int r = 0; r < 16; r++) begin
      txn(1'b0, 2'(r), 1'(r >> 2), 4'(r * 5), 4'(r), 16'(r * 16'h1357 + 16'h0F0F),
          32'hA5C3_0000 ^ (32'(r) * 32'h0101_0107), 10'd0, 17'(r % 3), 1'b0);
    end
    // Read command (type 11, payload FFFF) and write-and-commit
    txn(1'b0, 2'b11, 1'b0, 4'h0, 4'h2, 16'hFFFF, 32'h0123_4567, 10'd0, 17'd4, 1'b0);
    txn(1'b0, 2'b00, 1'b0, 4'h0, 4'h1, 16'h03E8, 32'hFFFF_FFFF, 10'd0, 17'd0, 1'b0);
    // Idle frames ignore fields
    txn(1'b1, 2'b01, 1'b1, 4'h3, 4'h9, 16'h1234, 32'h0000_0001, 10'd0, 17'd2, 1'b0);
    txn(1'b1, 2'b10, 1'b0, 4'hC, 4'h6, 16'h0000, 32'h8000_0000, 10'd0, 17'd0, 1'b0);
    // Divider and gap variants
    txn(1'b0, 2'b11, 1'b1, 4'h5, 4'hA, 16'hBEEF, 32'hDEAD_BEEF, 10'd1, 17'd7, 1'b0);
    txn(1'b0, 2'b00, 1'b0, 4'hF, 4'hF, 16'h8001, 32'h5555_AAAA, 10'd3, 17'd25, 1'b0);
    // Command presented while busy is ignored (R6)
    txn(1'b0, 2'b01, 1'b0, 4'h2, 4'h4, 16'h4242, 32'h1357_9BDF, 10'd0, 17'd3, 1'b1);
    @(negedge clk);
    chk("R6 no second exchange after poke", {31'd0, busy}, 32'd0);

    // R9 clear, reply held
    done_clr = 1;
    @(negedge clk);
    done_clr = 0;
    chk("R9 done cleared", {31'd0, done}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R9 done stays clear", {31'd0, done}, 32'd0);
    chk("R8 reply held at rest", rsp_data, 32'h1357_9BDF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule